// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Unit

This block collects error reports from a CAN protocol engine and turns them into software-visible sticky flags and a single interrupt request. Eight error-event pulses from the engine set bits in an error-flag register. An error-enable register of the same layout selects which of those flags take part in the error summary. Bit-level error causes (stuff, form, ACK, CRC, the two bit-error polarities and ACK delimiter) are recorded in a separate error-code register. That register either keeps only the cause of the most recent error or accumulates causes until software clears them.

The error summary joins two FIFO notifications (transmit and receive) in an interrupt status register. An interrupt enable register gates the status bits onto one interrupt line. Software writes single bytes through a small write port that selects one of five registers. All sticky flags are cleared by writing 0 to the flag and 1 to every flag that must stay. An event that arrives in the same cycle as the clear wins over the clear.

Top module: `can_err_irq_unit`

## Requirements
- R1: After reset all five registers read zero and `irq_o` is low.
- R2: An event pulse on `err_evt_i[k]` sets `err_flag_o[k]` in the next cycle. The bit meanings are: 7 bus lock, 6 overload frame sent, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning, 0 bus error.
- R3: A write selects its target by `wr_sel_i`: 0 error flags, 1 error enable, 2 error code, 3 interrupt status, 4 interrupt enable; other codes change nothing. On flag registers, a 0 in a data bit clears that flag and a 1 leaves it as it was.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag is set after that cycle.
- R5: The error-enable register is written as plain data. Interrupt status bit 5 reads 1 in the same cycle that any error flag and its enable bit are both 1, and reads 0 once no enabled flag remains set.
- R6: Error-code bit 7 is a plain mode bit written by software. Bits 6 to 0 are, in order, ACK-delimiter error, dominant bit error, recessive bit error, CRC error, ACK error, form error and stuff error. They are set by `code_evt_i[6:0]` and cleared by writing 0. With mode 1, new causes are ORed onto the held ones.
- R7: With mode 0, a cycle carrying any code event replaces bits 6 to 0 with exactly that event's causes, whatever a write in the same cycle asks for.
- R8: Interrupt status bit 4 latches `rx_fifo_evt_i` and bit 3 latches `tx_fifo_evt_i`. Both clear by writing 0. Bit 5 ignores writes, and status bits 7, 6 and 2 to 0 always read 0.
- R9: The interrupt enable register holds bits 5, 4 and 3 (other bits read 0). `irq_o` is 1 exactly when some status bit among 5, 4 and 3 is 1 together with its enable bit.
- R10: `irq_o` and the status register respond in the cycle after the event or write that changes them; there is no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | 8 | Error event pulses from the protocol engine |
| code_evt_i | input | 7 | Bit-level error cause pulses |
| tx_fifo_evt_i | input | 1 | Transmit FIFO notification pulse |
| rx_fifo_evt_i | input | 1 | Receive FIFO notification pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 8 | Write data byte |
| err_flag_o | output | 8 | Error flag register |
| err_enable_o | output | 8 | Error enable register |
| err_code_o | output | 8 | Error code register with mode in bit 7 |
| int_status_o | output | 8 | Interrupt status register |
| int_enable_o | output | 8 | Interrupt enable register |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong flag state shows at the register outputs one cycle after the event or write that caused it. Every register is visible as a port, so the bench compares all of them and the interrupt line against a reference model after every cycle. A summary or interrupt that disagrees with the flags and enables shows up in that same cycle. The error-code mode cannot hide a fault for long, because the next code event overwrites or ORs the flags in a way that differs between the two modes.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int BYTE_W   = 8;
  localparam int CODE_W   = 7;
  localparam int MODE_BIT = 7;
  localparam int IS_ERR   = 5;
  localparam int IS_RX    = 4;
  localparam int IS_TX    = 3;
  localparam int FIFO_W   = 2;
  localparam int SRC_W    = 3;

  typedef enum logic [2:0] {
    SEL_EFLAG = 3'd0,
    SEL_EEN   = 3'd1,
    SEL_CODE  = 3'd2,
    SEL_ISTAT = 3'd3,
    SEL_IEN   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/can_w0c_flags.sv
module can_w0c_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_mask_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q, flags_d;
  logic         flags_en;

  assign flags_en = wr_i | (|set_i);

  always_comb begin
    flags_d = flags_q;
    if (wr_i) flags_d = flags_d & wr_mask_i;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R2 and R4: an event always leaves its flag set, even against a clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R3: write-zero-to-clear, ones keep
  p_w0c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && set_i == '0) |=> (flags_o == ($past(flags_o) & $past(wr_mask_i))));
endmodule

// File: rtl/can_err_code.sv
module can_err_code #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         wr_i,
  input  logic [W:0]   wr_data_i,
  output logic         accum_o,
  output logic [W-1:0] flags_o
);
  logic         mode_q, mode_d;
  logic [W-1:0] flags_q, flags_d, kept;
  logic         any_evt;
  logic         upd_en;

  assign any_evt = |evt_i;
  assign upd_en  = wr_i | any_evt;

  always_comb begin
    mode_d = wr_i ? wr_data_i[W] : mode_q;
    kept   = wr_i ? (flags_q & wr_data_i[W-1:0]) : flags_q;
    if (!any_evt)    flags_d = kept;
    else if (mode_q) flags_d = kept | evt_i;
    else             flags_d = evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      flags_q <= '0;
    end else if (upd_en) begin
      mode_q  <= mode_d;
      flags_q <= flags_d;
    end
  end

  assign accum_o = mode_q;
  assign flags_o = flags_q;

  // R7: latest-only mode keeps just the newest cause set
  p_latest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accum_o && evt_i != '0) |=> (flags_o == $past(evt_i)));

  // R6: accumulate mode ORs new causes onto held ones
  p_accum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accum_o && evt_i != '0 && !wr_i) |=> (flags_o == ($past(flags_o) | $past(evt_i))));
endmodule

// File: rtl/can_irq_agg.sv
module can_irq_agg
  import can_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_pend_i,
  input  logic              rx_evt_i,
  input  logic              tx_evt_i,
  input  logic              stat_wr_i,
  input  logic [FIFO_W-1:0] stat_mask_i,
  input  logic              en_wr_i,
  input  logic [SRC_W-1:0]  en_data_i,
  output logic [SRC_W-1:0]  status_o,
  output logic [SRC_W-1:0]  enable_o,
  output logic              irq_o
);
  logic [FIFO_W-1:0] fifo_flags;
  logic [SRC_W-1:0]  en_q, en_d;

  can_w0c_flags #(.W(FIFO_W)) u_fifo_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     ({rx_evt_i, tx_evt_i}),
    .wr_i      (stat_wr_i),
    .wr_mask_i (stat_mask_i),
    .flags_o   (fifo_flags)
  );

  always_comb en_d = en_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= en_d;
  end

  assign status_o = {err_pend_i, fifo_flags};
  assign enable_o = en_q;
  assign irq_o    = |(status_o & en_q);

  // R9: nothing enabled means no interrupt
  p_no_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o == '0) |-> !irq_o);
endmodule

// File: rtl/can_err_irq_unit.sv
module can_err_irq_unit
  import can_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] err_evt_i,
  input  logic [CODE_W-1:0] code_evt_i,
  input  logic              tx_fifo_evt_i,
  input  logic              rx_fifo_evt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] err_flag_o,
  output logic [BYTE_W-1:0] err_enable_o,
  output logic [BYTE_W-1:0] err_code_o,
  output logic [BYTE_W-1:0] int_status_o,
  output logic [BYTE_W-1:0] int_enable_o,
  output logic              irq_o
);
  logic              wr_eflag, wr_een, wr_code, wr_istat, wr_ien;
  logic [BYTE_W-1:0] een_q, een_d;
  logic              err_pend;
  logic              code_mode;
  logic [CODE_W-1:0] code_flags;
  logic [SRC_W-1:0]  src_stat, src_en;

  assign wr_eflag = wr_en_i && (wr_sel_i == SEL_EFLAG);
  assign wr_een   = wr_en_i && (wr_sel_i == SEL_EEN);
  assign wr_code  = wr_en_i && (wr_sel_i == SEL_CODE);
  assign wr_istat = wr_en_i && (wr_sel_i == SEL_ISTAT);
  assign wr_ien   = wr_en_i && (wr_sel_i == SEL_IEN);

  can_w0c_flags #(.W(BYTE_W)) u_err_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (err_evt_i),
    .wr_i      (wr_eflag),
    .wr_mask_i (wr_data_i),
    .flags_o   (err_flag_o)
  );

  always_comb een_d = wr_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      een_q <= '0;
    else if (wr_een) een_q <= een_d;
  end

  assign err_pend = |(err_flag_o & een_q);

  can_err_code #(.W(CODE_W)) u_code (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (code_evt_i),
    .wr_i      (wr_code),
    .wr_data_i (wr_data_i),
    .accum_o   (code_mode),
    .flags_o   (code_flags)
  );

  can_irq_agg u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_pend_i  (err_pend),
    .rx_evt_i    (rx_fifo_evt_i),
    .tx_evt_i    (tx_fifo_evt_i),
    .stat_wr_i   (wr_istat),
    .stat_mask_i (wr_data_i[IS_RX:IS_TX]),
    .en_wr_i     (wr_ien),
    .en_data_i   (wr_data_i[IS_ERR:IS_TX]),
    .status_o    (src_stat),
    .enable_o    (src_en),
    .irq_o       (irq_o)
  );

  assign err_enable_o = een_q;
  assign err_code_o   = {code_mode, code_flags};

  always_comb begin
    int_status_o = '0;
    int_enable_o = '0;
    int_status_o[IS_ERR:IS_TX] = src_stat;
    int_enable_o[IS_ERR:IS_TX] = src_en;
  end

  // R5: an enabled flag raises the error summary in the same cycle
  p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_flag_o & err_enable_o) != '0) |-> int_status_o[IS_ERR]);

  // R8: reserved status bits never read one
  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_status_o[7:6] == 2'b00) && (int_status_o[2:0] == 3'b000));

  // R9: interrupt only with a status bit set
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (int_status_o != '0));
endmodule

// File: tb/can_err_irq_unit_bench.sv
module can_err_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] err_evt;
  logic [6:0] code_evt;
  logic       tx_evt, rx_evt;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] err_flag, err_en, err_code, int_stat, int_en;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [7:0] m_flag, m_een;
  logic       m_mode;
  logic [6:0] m_code;
  logic       m_rx, m_tx;
  logic [2:0] m_ien;

  always #2 clk = ~clk;

  can_err_irq_unit u_can_err_irq_unit (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt), .code_evt_i(code_evt),
    .tx_fifo_evt_i(tx_evt), .rx_fifo_evt_i(rx_evt), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .err_flag_o(err_flag),
    .err_enable_o(err_en), .err_code_o(err_code), .int_status_o(int_stat),
    .int_enable_o(int_en), .irq_o(irq)
  );

  function automatic logic [7:0] exp_stat();
    return {2'b00, |(m_flag & m_een), m_rx, m_tx, 3'b000};
  endfunction

  function automatic logic exp_irq();
    logic [2:0] s;
    s = {|(m_flag & m_een), m_rx, m_tx};
    return |(s & m_ien);
  endfunction

  task automatic model_step();
    logic [6:0] kept;
    if (wr_en && wr_sel == 3'd0) m_flag = m_flag & wr_data;
    m_flag = m_flag | err_evt;
    if (wr_en && wr_sel == 3'd1) m_een = wr_data;
    kept = (wr_en && wr_sel == 3'd2) ? (m_code & wr_data[6:0]) : m_code;
    if (code_evt == 7'd0)  m_code = kept;
    else if (m_mode)       m_code = kept | code_evt;
    else                   m_code = code_evt;
    if (wr_en && wr_sel == 3'd2) m_mode = wr_data[7];
    if (wr_en && wr_sel == 3'd3) begin
      m_rx = m_rx & wr_data[4];
      m_tx = m_tx & wr_data[3];
    end
    m_rx = m_rx | rx_evt;
    m_tx = m_tx | tx_evt;
    if (wr_en && wr_sel == 3'd4) m_ien = wr_data[5:3];
  endtask

  task automatic compare(input string req);
    logic bad;
    bad = 1'b0;
    n_tests++;
    if (err_flag !== m_flag) begin
      $display("FAIL %s err_flag act=%h exp=%h", req, err_flag, m_flag); bad = 1'b1;
    end
    if (err_en !== m_een) begin
      $display("FAIL %s err_enable act=%h exp=%h", req, err_en, m_een); bad = 1'b1;
    end
    if (err_code !== {m_mode, m_code}) begin
      $display("FAIL %s err_code act=%h exp=%h", req, err_code, {m_mode, m_code}); bad = 1'b1;
    end
    if (int_stat !== exp_stat()) begin
      $display("FAIL %s int_status act=%h exp=%h", req, int_stat, exp_stat()); bad = 1'b1;
    end
    if (int_en !== {2'b00, m_ien, 3'b000}) begin
      $display("FAIL %s int_enable act=%h exp=%h", req, int_en, {2'b00, m_ien, 3'b000}); bad = 1'b1;
    end
    if (irq !== exp_irq()) begin
      $display("FAIL %s irq act=%b exp=%b", req, irq, exp_irq()); bad = 1'b1;
    end
    if (bad) n_fail++;
  endtask

  task automatic idle_inputs();
    err_evt = '0; code_evt = '0; tx_evt = 1'b0; rx_evt = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
  endtask

  // called at a negedge with inputs already set; one clock, then check
  task automatic step(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_inputs();
    compare(req);
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input string req);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step(req);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    rst_n = 1'b0;
    m_flag = '0; m_een = '0; m_mode = 1'b0; m_code = '0;
    m_rx = 1'b0; m_tx = 1'b0; m_ien = '0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2: bus-off entry is bit 3
    err_evt = 8'h08; step("R2 bus-off entry");
    if (err_flag !== 8'h08) begin
      n_fail++; $display("FAIL R2 act=%h exp=08", err_flag);
    end
    n_tests++;
    // R5: flag without enable -> no summary; then enable
    wr(3'd1, 8'h08, "R5 enable write");
    if (int_stat[5] !== 1'b1) begin
      n_fail++; $display("FAIL R5 summary act=%b exp=1", int_stat[5]);
    end
    n_tests++;
    // R9 + R10: enable summary interrupt
    wr(3'd4, 8'h20, "R9 irq enable");
    // R8: summary bit ignores writes
    wr(3'd3, 8'h00, "R8 summary not writable");
    // R3: clear with inverted mask
    wr(3'd0, 8'hF7, "R3 clear bus-off entry");
    if (irq !== 1'b0 || int_stat[5] !== 1'b0) begin
      n_fail++; $display("FAIL R5 clear act=%b exp=0", int_stat[5]);
    end
    n_tests++;
    // R3: unused select changes nothing
    wr(3'd7, 8'h00, "R3 unused select");
    // R4: event and clear same cycle
    err_evt = 8'h81; step("R4 setup");
    err_evt = 8'h01; wr(3'd0, 8'h00, "R4 event beats clear");
    // R7: latest-only mode
    code_evt = 7'h41; step("R7 first cause");
    code_evt = 7'h08; step("R7 replace");
    code_evt = 7'h02; wr(3'd2, 8'h00, "R7 event beats write");
    // R6: accumulate mode
    wr(3'd2, 8'hFF, "R6 mode on");
    code_evt = 7'h10; step("R6 accumulate");
    code_evt = 7'h04; step("R6 accumulate two");
    wr(3'd2, 8'hEF, "R6 clear one cause");
    // R8: FIFO status bits
    rx_evt = 1'b1; step("R8 rx latch");
    tx_evt = 1'b1; wr(3'd4, 8'h18, "R8 tx latch and R9 enable");
    wr(3'd3, 8'hEF, "R8 clear rx");
    tx_evt = 1'b1; wr(3'd3, 8'h00, "R8 tx set beats clear");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      err_evt  = (r[3:0] == 4'd0) ? 8'(1 << r[6:4]) : 8'h00;
      code_evt = (r[9:7] == 3'd0) ? 7'($urandom) : 7'h00;
      tx_evt   = (r[13:10] == 4'd0);
      rx_evt   = (r[17:14] == 4'd0);
      wr_en    = (r[19:18] == 2'd0);
      wr_sel   = 3'(r[22:20] % 3'd6);
      wr_data  = 8'($urandom);
      step("R2-R10 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule